// File: doc/BRIEF.md
# Prescaled Free-Running Timer Counter

This block keeps a 16-bit count that advances without stopping, one step per tick of a prescaler fed by the system clock. The prescaler divides by 1, 4, 8 or 16. The full count is also driven out on a port, so that capture and compare logic elsewhere on the chip can use it. Software sees the block through a byte-wide register port. Reading the high byte takes a snapshot of the low byte, so a two-access read of the count never mixes two different values.

The divide ratio can be set once, and only during a short setup window after reset leaves its asserted state. Whenever the count wraps from its maximum value to zero, an overflow flag is set. That flag raises an interrupt request when the interrupt is enabled. A test-mode input turns a write to the high byte into a preset of the count to a value just below the wrap point, so the overflow path can be reached in a few cycles.

The register port and the interrupt line are plain control and status signals. The block has no data stream, so it has no valid/ready handshake: every access completes in the cycle in which it is presented.

Top module: `prescaled_timer`

## Requirements
- R1: While reset is asserted, and right after it is released, the count is 0x0000, the control and flag registers read 0x00 and irq is low.
- R2: The count rises by exactly one per prescaler tick. The divide code in control bits [1:0] means 0 = /1, 1 = /4, 2 = /8 and 3 = /16, and over any 64 cycles the count rises by 64 divided by the ratio.
- R3: The divide code takes the first write to the control register (address 2) only, and only if that write lands on one of the first 64 rising edges after reset release. Any later write leaves the code unchanged. Control bit 7 stays writable at all times.
- R4: A read of address 0 returns count[15:8] and, at the end of that cycle, copies count[7:0] into a holding byte. A read of address 1 returns the holding byte, not the live low byte. Reset does not clear the holding byte.
- R5: Outside test mode, a write to address 0 or address 1 has no effect on the count.
- R6: With test_mode high, a write to address 0 loads 0xFFF8 into the count on that edge, whatever the write data.
- R7: When the count steps from 0xFFFF to 0x0000, flag bit 7 (address 3) becomes 1.
- R8: Writing a 1 to flag bit 7 clears the flag and writing a 0 leaves it as it was. A wrap in the same cycle wins over the clear.
- R9: irq is high exactly while the flag is set and the enable (control bit 7) is 1.
- R10: Every register read returns the value held at the start of the access cycle, combinationally, in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_mode | input | 1 | Enables the preset on a high-byte write |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 high byte, 1 held low byte, 2 control, 3 flag |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| count | output | 16 | Live count for neighbouring channels |
| irq | output | 1 | Overflow interrupt request |

## Verification
Read data is combinational, so the bench samples it 1 ns after driving a read on the falling edge. Writes, presets and the low-byte snapshot take effect at the next rising edge, so their results are checked from the following falling edge onward. Overflow is timed from the preset: the count is 0xFFFF in the seventh cycle after the preset edge and wraps on the eighth edge, and the high-byte read is placed in that seventh cycle. Divide ratios are measured between snapshots taken exactly 64 cycles apart, which makes the expected step count independent of the prescaler phase.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam logic [1:0] ADDR_CNT_HI = 2'd0;
  localparam logic [1:0] ADDR_CNT_LO = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam logic [1:0] ADDR_FLAG   = 2'd3;

  typedef enum logic [1:0] {
    DIV_1  = 2'd0,
    DIV_4  = 2'd1,
    DIV_8  = 2'd2,
    DIV_16 = 2'd3
  } div_sel_e;

  // number of prescaler bits that must all be 1 for a tick
  function automatic int unsigned div_shift(div_sel_e s);
    case (s)
      DIV_1:   return 0;
      DIV_4:   return 2;
      DIV_8:   return 3;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/ptc_prescaler.sv
module ptc_prescaler
  import ptc_pkg::*;
#(
  parameter int MAX_SHIFT = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  div_sel_e sel,
  output logic     tick
);
  logic [MAX_SHIFT-1:0] pcnt;
  logic [MAX_SHIFT-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt <= '0;
    else        pcnt <= pcnt + 1'b1;
  end

  always_comb begin
    mask = MAX_SHIFT'((1 << div_shift(sel)) - 1);
    tick = &(pcnt | ~mask);
  end
endmodule

// File: rtl/ptc_setup_window.sv
module ptc_setup_window #(
  parameter int WINDOW = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_req,
  output logic accept,
  output logic locked
);
  localparam int WIN_W = $clog2(WINDOW + 1);

  logic [WIN_W-1:0] elapsed;
  logic             written;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
      written <= 1'b0;
    end else begin
      if (elapsed != WIN_W'(WINDOW)) elapsed <= elapsed + 1'b1;
      if (accept) written <= 1'b1;
    end
  end

  assign locked = written || (elapsed == WIN_W'(WINDOW));
  assign accept = wr_req && !locked;
endmodule

// File: rtl/ptc_counter.sv
module ptc_counter #(
  parameter int          W      = 16,
  parameter logic [W-1:0] PRESET = 16'hFFF8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         preset,
  output logic [W-1:0] value,
  output logic         wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value <= '0;
    else if (preset) value <= PRESET;
    else if (tick)   value <= value + 1'b1;
  end

  assign wrap = tick && !preset && (&value);
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import ptc_pkg::*;
#(
  parameter int             CNT_W      = 16,
  parameter logic [CNT_W-1:0] PRESET_VAL = 16'hFFF8,
  parameter int             WINDOW     = 64,
  parameter int             MAX_SHIFT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_mode,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  localparam int BYTE = 8;

  logic     tick, wrap, accept, sel_locked;
  logic     ovf_flag, ovf_ie;
  div_sel_e pre_sel;
  logic [BYTE-1:0] lo_hold;

  logic rd_hi, wr_hi, wr_ctrl, wr_flag;
  assign rd_hi   = bus_sel && !bus_wr && (bus_addr == ADDR_CNT_HI);
  assign wr_hi   = bus_sel &&  bus_wr && (bus_addr == ADDR_CNT_HI);
  assign wr_ctrl = bus_sel &&  bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_flag = bus_sel &&  bus_wr && (bus_addr == ADDR_FLAG);

  ptc_prescaler #(.MAX_SHIFT(MAX_SHIFT)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(pre_sel), .tick(tick)
  );

  ptc_setup_window #(.WINDOW(WINDOW)) u_win (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_ctrl),
    .accept(accept), .locked(sel_locked)
  );

  ptc_counter #(.W(CNT_W), .PRESET(PRESET_VAL)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .preset(wr_hi && test_mode), .value(count), .wrap(wrap)
  );

  // snapshot of the low byte, deliberately left out of reset
  always_ff @(posedge clk) begin
    if (rd_hi) lo_hold <= count[BYTE-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_ie  <= 1'b0;
      pre_sel <= DIV_1;
    end else begin
      if (wr_ctrl) ovf_ie  <= bus_wdata[7];
      if (accept)  pre_sel <= div_sel_e'(bus_wdata[1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       ovf_flag <= 1'b0;
    else if (wrap)                    ovf_flag <= 1'b1;
    else if (wr_flag && bus_wdata[7]) ovf_flag <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      ADDR_CNT_HI: bus_rdata = count[CNT_W-1 -: BYTE];
      ADDR_CNT_LO: bus_rdata = lo_hold;
      ADDR_CTRL:   bus_rdata = {ovf_ie, 5'b0, pre_sel};
      default:     bus_rdata = {ovf_flag, 7'b0};
    endcase
  end

  assign irq = ovf_flag && ovf_ie;
endmodule

// File: rtl/prescaled_timer_chk.sv
module prescaled_timer_chk #(
  parameter int               CNT_W      = 16,
  parameter logic [CNT_W-1:0] PRESET_VAL = 16'hFFF8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             test_mode,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [7:0]       bus_wdata,
  input logic [CNT_W-1:0] count,
  input logic             irq,
  input logic             ovf_flag,
  input logic             ovf_ie,
  input logic [1:0]       pre_sel,
  input logic             sel_locked
);
  // R2: the count only moves by one, or jumps to the preset value
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> ((count == $past(count) + 1'b1) || (count == PRESET_VAL)));

  // R3: once locked, the divide code does not move
  a_r3_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    sel_locked |=> $stable(pre_sel));

  // R6: a test-mode write to the high byte presets the count
  a_r6_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && bus_sel && bus_wr && bus_addr == 2'd0) |=> (count == PRESET_VAL));

  // R7: a wrap leaves the flag set
  a_r7_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(count) == '1) && (count == '0)) |-> ovf_flag);

  // R8: a clear with no pending wrap drops the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd3 && bus_wdata[7] && !(&count)) |=> !ovf_flag);

  // R9: an enabled wrap requests an interrupt
  a_r9_irq_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ie && ($past(count) == '1) && (count == '0)) |-> irq);
endmodule

bind prescaled_timer prescaled_timer_chk #(.CNT_W(CNT_W), .PRESET_VAL(PRESET_VAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .count(count), .irq(irq), .ovf_flag(ovf_flag), .ovf_ie(ovf_ie),
  .pre_sel(pre_sel), .sel_locked(sel_locked)
);

// File: tb/prescaled_timer_test.sv
`timescale 1ns/1ps
module prescaled_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        test_mode = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic [15:0] count;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  prescaled_timer uut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .count(count), .irq(irq)
  );

  always #4 clk = ~clk;

  // {divide code, write delay in cycles, expected rise over 64 cycles}
  localparam logic [17:0] VEC [6] = '{
    {2'd0, 8'd0,  8'd64},
    {2'd1, 8'd0,  8'd16},
    {2'd2, 8'd5,  8'd8},
    {2'd3, 8'd63, 8'd4},
    {2'd3, 8'd64, 8'd64},
    {2'd1, 8'd40, 8'd16}
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic read16(output logic [15:0] v);
    logic [7:0] hi, lo;
    bus_read(2'd0, hi);
    bus_read(2'd1, lo);
    v = {hi, lo};
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v1, v2;

    // R1: state while reset is held
    repeat (2) @(negedge clk);
    bus_read(2'd0, b);   check("R1 hi during reset", {8'd0, b}, 16'h0000);
    bus_read(2'd2, b);   check("R1 ctrl during reset", {8'd0, b}, 16'h0000);
    bus_read(2'd3, b);   check("R1 flag during reset", {8'd0, b}, 16'h0000);
    check("R1 count port", count, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);

    // R2/R3 table: divide codes and window boundary
    for (int i = 0; i < 6; i++) begin
      logic [1:0] sel;
      logic [7:0] dly, rise;
      {sel, dly, rise} = VEC[i];
      do_reset();
      repeat (int'(dly)) @(negedge clk);
      bus_write(2'd2, {6'd0, sel});
      bus_read(2'd2, b);
      check("R3 ctrl code", {8'd0, b}, (dly < 8'd64) ? {14'd0, sel} : 16'h0000);
      read16(v1);
      repeat (62) @(negedge clk);
      read16(v2);
      check("R2 rise over 64 cycles", v2 - v1, {8'd0, rise});
    end

    // R3: a second write inside the window is ignored
    do_reset();
    bus_write(2'd2, 8'h01);
    repeat (2) @(negedge clk);
    bus_write(2'd2, 8'h03);
    bus_read(2'd2, b);
    check("R3 second write ignored", {8'd0, b}, 16'h0001);

    // R3/R9: enable bit writable after the window, code kept
    do_reset();
    repeat (70) @(negedge clk);
    bus_write(2'd2, 8'h83);
    bus_read(2'd2, b);
    check("R3 enable taken code kept", {8'd0, b}, 16'h0080);
    check("R9 irq low without flag", {15'd0, irq}, 16'h0000);

    // R5: high and low byte writes outside test mode
    read16(v1);
    bus_write(2'd0, 8'h12);
    bus_write(2'd1, 8'h34);
    read16(v2);
    check("R5 count unaffected", v2 - v1, 16'd4);

    // R6: preset, then R4 snapshot across the wrap
    test_mode = 1'b1;
    bus_write(2'd0, 8'h5A);
    test_mode = 1'b0;
    check("R6 preset value", count, 16'hFFF8);
    repeat (7) @(negedge clk);
    bus_read(2'd0, b);
    check("R4 high byte at FFFF", {8'd0, b}, 16'h00FF);
    check("R10 live count wrapped", count, 16'h0000);
    bus_read(2'd1, b);
    check("R4 held low byte", {8'd0, b}, 16'h00FF);

    // R7/R8/R9
    bus_read(2'd3, b);
    check("R7 flag set", {8'd0, b}, 16'h0080);
    check("R9 irq high", {15'd0, irq}, 16'h0001);
    bus_write(2'd3, 8'h00);
    bus_read(2'd3, b);
    check("R8 write zero keeps flag", {8'd0, b}, 16'h0080);
    bus_write(2'd3, 8'h80);
    bus_read(2'd3, b);
    check("R8 write one clears", {8'd0, b}, 16'h0000);
    check("R9 irq low after clear", {15'd0, irq}, 16'h0000);

    finish_run();
  end
endmodule